// File: doc/BRIEF.md
# Error-Protected Doubleword Memory Path

This block wraps a small synchronous RAM that holds 64-bit doublewords. When a doubleword is written, the block derives redundant check bits from it and stores them in the same RAM row. When a doubleword is read, the block derives the check bits again from the stored data and compares them with the stored check bits. It then reports a correctable or an uncorrectable error together with the address. Depending on two control inputs, it returns either the repaired doubleword or the stored doubleword unchanged.

The protection code is chosen when the block is built, through the `SCHEME` parameter. Three codes are available. The first is a parity bit for each byte. The second is one single-error-correcting, double-error-detecting (SECDED) code spanning all 64 bits. The third is two independent SECDED codes, one for each 32-bit half. At run time, software can only switch checking on or off and choose between detect-only and correcting behaviour. A static strap input sets the parity sense. For test, two mask inputs are XORed into the data and the check bits on their way into the RAM, so single and multiple bit errors can be planted.

Top module: `ecc_mem_path`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid`, `err_ce` and `err_ue` are low, and an error flag is never high without `rd_valid`.
- R2: A read request returns exactly one `rd_valid` pulse in the next cycle, with `err_addr` equal to the request address. Reads may be issued in consecutive cycles. A write never produces `rd_valid`.
- R3: With no injected errors, every scheme returns the written doubleword unchanged and raises no error flag.
- R4: Parity scheme: check bit b holds the XOR of data bits [8b+7:8b], inverted when `cfg_odd_parity` is 1. A single flipped bit in any byte or in its check bit raises `err_ue` and is never corrected. Flips in up to eight different bytes are still flagged.
- R5: Parity scheme: two flipped bits in the same byte raise no flag, and the stored data is returned.
- R6: 64-bit SECDED: one flipped bit anywhere in the 72-bit stored word (64 data bits plus 8 check bits) raises `err_ce`, and the corrected doubleword is returned.
- R7: 64-bit SECDED: two flipped bits in the 72-bit word raise `err_ue` with `err_ce` low, and the stored data is returned.
- R8: Dual 32-bit SECDED: bits [31:0] with check bits [6:0], and bits [63:32] with check bits [13:7], form separate code groups. One flip in each group is corrected with `err_ce`. Two flips in one group raise `err_ue`.
- R9: With `ctl_en` low at the read request, the stored data is returned and no flag is raised.
- R10: With `ctl_en` high and `ctl_correct` low, a correctable error raises `err_ce`, but the stored data is returned unrepaired.
- R11: Parity sense is taken from `cfg_odd_parity` at write time and at read time. In the parity scheme, a word written under one sense and read under the other raises `err_ue` with the stored data.
- R12: If any code group is uncorrectable, `err_ce` stays low and `err_ue` is raised. In correcting mode, groups that are correctable are still repaired in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Row address |
| req_wdata | input | 64 | Write doubleword |
| inj_data_mask | input | 64 | XOR mask applied to stored data on write (test) |
| inj_chk_mask | input | CW | XOR mask applied to stored check bits on write (test) |
| ctl_en | input | 1 | Checking enable, sampled with a read |
| ctl_correct | input | 1 | 1 = return repaired data, 0 = detect only |
| cfg_odd_parity | input | 1 | Static parity sense (1 = odd) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read doubleword |
| err_ce | output | 1 | Correctable error pulse |
| err_ue | output | 1 | Uncorrectable error pulse |
| err_addr | output | AW | Address of the returned read |

## Verification
One instance of each scheme is driven with clean patterns: all zeros, all ones, alternating nibbles and a counting value. These show that encoder and checker agree for every scheme. Single flips in data bits, in Hamming bits and in the overall bit separate correction from detection. Double flips, placed in one group or spread across groups, separate the detect-only limit of each code and the precedence of uncorrectable over correctable. Rereading the same planted fault with checking disabled, then in detect-only mode, shows that both controls change only the returned data and the flags. A polarity swap between write and read shows that the strap reaches both sides.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int DATA_W = 64;
  localparam int NBYTE  = DATA_W / 8;

  typedef enum logic [1:0] {
    SCH_PARITY = 2'd0,
    SCH_SEC64  = 2'd1,
    SCH_SEC32  = 2'd2
  } scheme_e;

  // number of independent SECDED groups
  function automatic int grp_cnt(scheme_e s);
    return (s == SCH_SEC32) ? 2 : 1;
  endfunction

  function automatic int grp_data(scheme_e s);
    return DATA_W / grp_cnt(s);
  endfunction

  // Hamming bits per group (overall parity bit not included)
  function automatic int grp_ham(scheme_e s);
    return (s == SCH_SEC32) ? 6 : 7;
  endfunction

  function automatic int chk_width(scheme_e s);
    return (s == SCH_PARITY) ? NBYTE : grp_cnt(s) * (grp_ham(s) + 1);
  endfunction

  // Hamming check bits: data bits occupy the non power-of-two code
  // positions 3,5,6,7,9...; check bit i covers positions with bit i set.
  function automatic logic [7:0] ham_bits(logic [63:0] d, int k, int r);
    logic [7:0] c;
    int idx;
    c   = '0;
    idx = 0;
    for (int p = 1; p < 128; p++) begin
      if (p <= k + r && (p & (p - 1)) != 0) begin
        if (idx < 64 && d[idx]) begin
          for (int i = 0; i < 8; i++) begin
            if (i < r && p[i]) c[i] = ~c[i];
          end
        end
        idx++;
      end
    end
    return c;
  endfunction

  // one-hot data mask of the bit sitting at code position s
  function automatic logic [63:0] ham_flip(logic [7:0] s, int k, int r);
    logic [63:0] f;
    int idx;
    f   = '0;
    idx = 0;
    for (int p = 1; p < 128; p++) begin
      if (p <= k + r && (p & (p - 1)) != 0) begin
        if (idx < 64 && p == int'(s)) f[idx] = 1'b1;
        idx++;
      end
    end
    return f;
  endfunction

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode #(
  parameter ecc_pkg::scheme_e SCHEME = ecc_pkg::SCH_SEC64,
  localparam int CW = ecc_pkg::chk_width(SCHEME)
) (
  input  logic [ecc_pkg::DATA_W-1:0] d,
  input  logic                       odd,
  output logic [CW-1:0]              c
);

  if (SCHEME == ecc_pkg::SCH_PARITY) begin : g_par
    for (genvar b = 0; b < ecc_pkg::NBYTE; b++) begin : g_byte
      assign c[b] = ^d[b*8 +: 8] ^ odd;
    end
  end else begin : g_sec
    localparam int NH = ecc_pkg::grp_cnt(SCHEME);
    localparam int KH = ecc_pkg::grp_data(SCHEME);
    localparam int RH = ecc_pkg::grp_ham(SCHEME);
    localparam int GW = RH + 1;
    for (genvar h = 0; h < NH; h++) begin : g_grp
      logic [KH-1:0] dseg;
      logic [RH-1:0] ham;
      assign dseg = d[h*KH +: KH];
      assign ham  = RH'(ecc_pkg::ham_bits(64'(dseg), KH, RH));
      // overall bit makes the whole group (data + Hamming + itself) even,
      // or odd under the odd strap
      assign c[h*GW +: GW] = {^dseg ^ ^ham ^ odd, ham};
    end
  end

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode #(
  parameter ecc_pkg::scheme_e SCHEME = ecc_pkg::SCH_SEC64,
  localparam int CW = ecc_pkg::chk_width(SCHEME)
) (
  input  logic [ecc_pkg::DATA_W-1:0] d,
  input  logic [CW-1:0]              c,
  input  logic                       odd,
  output logic [ecc_pkg::DATA_W-1:0] fixed,
  output logic                       ce,
  output logic                       ue
);

  if (SCHEME == ecc_pkg::SCH_PARITY) begin : g_par
    logic [ecc_pkg::NBYTE-1:0] bad;
    for (genvar b = 0; b < ecc_pkg::NBYTE; b++) begin : g_byte
      assign bad[b] = ^d[b*8 +: 8] ^ c[b] ^ odd;
    end
    assign fixed = d;
    assign ce    = 1'b0;
    assign ue    = |bad;
  end else begin : g_sec
    localparam int NH = ecc_pkg::grp_cnt(SCHEME);
    localparam int KH = ecc_pkg::grp_data(SCHEME);
    localparam int RH = ecc_pkg::grp_ham(SCHEME);
    localparam int GW = RH + 1;
    logic [NH-1:0] ce_g;
    logic [NH-1:0] ue_g;
    for (genvar h = 0; h < NH; h++) begin : g_grp
      logic [KH-1:0] dseg;
      logic [GW-1:0] cseg;
      logic [RH-1:0] syn;
      logic          odd_err;
      assign dseg    = d[h*KH +: KH];
      assign cseg    = c[h*GW +: GW];
      assign syn     = RH'(ecc_pkg::ham_bits(64'(dseg), KH, RH)) ^ cseg[RH-1:0];
      assign odd_err = ^dseg ^ ^cseg ^ odd;
      assign ce_g[h] = odd_err;
      assign ue_g[h] = !odd_err && (syn != '0);
      assign fixed[h*KH +: KH] =
        dseg ^ (odd_err ? KH'(ecc_pkg::ham_flip(8'(syn), KH, RH)) : '0);
    end
    assign ce = |ce_g;
    assign ue = |ue_g;
  end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int W  = 72,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end

endmodule

// File: rtl/ecc_mem_path.sv
module ecc_mem_path #(
  parameter ecc_pkg::scheme_e SCHEME = ecc_pkg::SCH_SEC64,
  parameter int AW = 4,
  localparam int CW = ecc_pkg::chk_width(SCHEME)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [ecc_pkg::DATA_W-1:0] req_wdata,
  input  logic [ecc_pkg::DATA_W-1:0] inj_data_mask,
  input  logic [CW-1:0]              inj_chk_mask,
  input  logic                       ctl_en,
  input  logic                       ctl_correct,
  input  logic                       cfg_odd_parity,
  output logic                       rd_valid,
  output logic [ecc_pkg::DATA_W-1:0] rd_data,
  output logic                       err_ce,
  output logic                       err_ue,
  output logic [AW-1:0]              err_addr
);

  localparam int DW = ecc_pkg::DATA_W;
  localparam int RW = DW + CW;

  logic          wr_req;
  logic          rd_req;
  logic [CW-1:0] enc_chk;
  logic [RW-1:0] row_wr;
  logic [RW-1:0] row_rd;
  logic [DW-1:0] raw_data;
  logic [CW-1:0] raw_chk;
  logic [DW-1:0] fix_data;
  logic          dec_ce;
  logic          dec_ue;

  logic          rv_q;
  logic [AW-1:0] addr_q;
  logic          en_q;
  logic          cor_q;
  logic          odd_q;

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  ecc_encode #(.SCHEME(SCHEME)) u_enc (
    .d   (req_wdata),
    .odd (cfg_odd_parity),
    .c   (enc_chk)
  );

  // fault injection sits after the encoder, so planted flips are real errors
  assign row_wr = {enc_chk ^ inj_chk_mask, req_wdata ^ inj_data_mask};

  ecc_store #(.W(RW), .AW(AW)) u_store (
    .clk  (clk),
    .we   (wr_req),
    .re   (rd_req),
    .addr (req_addr),
    .wd   (row_wr),
    .rd   (row_rd)
  );

  assign raw_data = row_rd[DW-1:0];
  assign raw_chk  = row_rd[RW-1:DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q   <= 1'b0;
      addr_q <= '0;
      en_q   <= 1'b0;
      cor_q  <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      rv_q <= rd_req;
      if (rd_req) begin
        addr_q <= req_addr;
        en_q   <= ctl_en;
        cor_q  <= ctl_correct;
        odd_q  <= cfg_odd_parity;
      end
    end
  end

  ecc_decode #(.SCHEME(SCHEME)) u_dec (
    .d     (raw_data),
    .c     (raw_chk),
    .odd   (odd_q),
    .fixed (fix_data),
    .ce    (dec_ce),
    .ue    (dec_ue)
  );

  assign rd_valid = rv_q;
  assign rd_data  = (en_q && cor_q) ? fix_data : raw_data;
  assign err_ue   = rv_q && en_q && dec_ue;
  assign err_ce   = rv_q && en_q && dec_ce && !dec_ue;
  assign err_addr = addr_q;

endmodule

// File: rtl/ecc_mem_path_sva.sv
module ecc_mem_path_sva #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          ctl_en,
  input logic          rd_valid,
  input logic          err_ce,
  input logic          err_ue,
  input logic [AW-1:0] err_addr
);

  a_r2_read_answers: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r2_addr_echo: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> (err_addr == $past(req_addr)));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !ctl_en) |=> (!err_ce && !err_ue));

  a_r12_ue_wins: assert property (@(posedge clk) disable iff (rst)
    err_ue |-> !err_ce);

  a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (err_ce || err_ue) |-> rd_valid);

endmodule

bind ecc_mem_path ecc_mem_path_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .ctl_en    (ctl_en),
  .rd_valid  (rd_valid),
  .err_ce    (err_ce),
  .err_ue    (err_ue),
  .err_addr  (err_addr)
);

// File: tb/ecc_mem_path_tb.sv
module ecc_mem_path_tb;

  localparam int AW = 4;

  typedef struct packed {
    logic [63:0]   d;
    logic          ce;
    logic          ue;
    logic [AW-1:0] a;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    vsel = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   dmask = '0;
  logic [13:0]   cmask = '0;
  logic          en = 1'b1;
  logic          cor = 1'b1;
  logic          odd = 1'b0;

  logic          rv   [3];
  logic [63:0]   rdat [3];
  logic          ce   [3];
  logic          ue   [3];
  logic [AW-1:0] ea   [3];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  exp_t  q0[$], q1[$], q2[$];
  string t0[$], t1[$], t2[$];

  always #5 clk = ~clk;

  // instance 0: byte parity
  ecc_mem_path #(.SCHEME(ecc_pkg::SCH_PARITY), .AW(AW)) u_dut_par (
    .clk(clk), .rst(rst), .req_valid(vsel[0]), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .inj_data_mask(dmask), .inj_chk_mask(cmask[7:0]),
    .ctl_en(en), .ctl_correct(cor), .cfg_odd_parity(odd),
    .rd_valid(rv[0]), .rd_data(rdat[0]), .err_ce(ce[0]), .err_ue(ue[0]), .err_addr(ea[0]));

  // instance 1: 64-bit SECDED (default build)
  ecc_mem_path #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(vsel[1]), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .inj_data_mask(dmask), .inj_chk_mask(cmask[7:0]),
    .ctl_en(en), .ctl_correct(cor), .cfg_odd_parity(odd),
    .rd_valid(rv[1]), .rd_data(rdat[1]), .err_ce(ce[1]), .err_ue(ue[1]), .err_addr(ea[1]));

  // instance 2: dual 32-bit SECDED
  ecc_mem_path #(.SCHEME(ecc_pkg::SCH_SEC32), .AW(AW)) u_dut_s32 (
    .clk(clk), .rst(rst), .req_valid(vsel[2]), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .inj_data_mask(dmask), .inj_chk_mask(cmask),
    .ctl_en(en), .ctl_correct(cor), .cfg_odd_parity(odd),
    .rd_valid(rv[2]), .rd_data(rdat[2]), .err_ce(ce[2]), .err_ue(ue[2]), .err_addr(ea[2]));

  function automatic logic [63:0] pat(int i);
    case (i)
      0:       return 64'h0;
      1:       return '1;
      2:       return 64'hA5A5_5A5A_0F0F_F0F0;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  task automatic judge(input exp_t e, input string t, input int k);
    n_chk++;
    if (rdat[k] !== e.d || ce[k] !== e.ce || ue[k] !== e.ue || ea[k] !== e.a) begin
      n_fail++;
      $display("FAIL %s inst%0d: data=%h ce=%b ue=%b addr=%h expected data=%h ce=%b ue=%b addr=%h",
               t, k, rdat[k], ce[k], ue[k], ea[k], e.d, e.ce, e.ue, e.a);
    end
  endtask

  task automatic orphan(input int k);
    n_chk++;
    n_fail++;
    $display("FAIL R2 inst%0d: rd_valid=1 expected 0 (no read outstanding)", k);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst) begin
      if (rv[0]) begin
        if (q0.size() == 0) orphan(0);
        else judge(q0.pop_front(), t0.pop_front(), 0);
      end
      if (rv[1]) begin
        if (q1.size() == 0) orphan(1);
        else judge(q1.pop_front(), t1.pop_front(), 1);
      end
      if (rv[2]) begin
        if (q2.size() == 0) orphan(2);
        else judge(q2.pop_front(), t2.pop_front(), 2);
      end
    end
  end

  task automatic push(input int k, input exp_t e, input string t);
    case (k)
      0: begin q0.push_back(e); t0.push_back(t); end
      1: begin q1.push_back(e); t1.push_back(t); end
      default: begin q2.push_back(e); t2.push_back(t); end
    endcase
  endtask

  task automatic do_write(input int k, input logic [AW-1:0] a, input logic [63:0] d,
                          input logic [63:0] dm, input logic [13:0] cm);
    @(negedge clk);
    vsel = 3'b001 << k; wr = 1'b1; addr = a; wdata = d; dmask = dm; cmask = cm;
    @(negedge clk);
    vsel = '0; wr = 1'b0; dmask = '0; cmask = '0;
    n_chk++;
    if (rv[k] !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 inst%0d: write gave rd_valid=%b expected 0", k, rv[k]);
    end
  endtask

  task automatic do_read(input int k, input logic [AW-1:0] a, input logic e_n, input logic c_r,
                         input logic [63:0] xd, input logic xce, input logic xue, input string t);
    @(negedge clk);
    vsel = 3'b001 << k; wr = 1'b0; addr = a; en = e_n; cor = c_r;
    push(k, '{d: xd, ce: xce, ue: xue, a: a}, t);
    @(negedge clk);
    vsel = '0;
  endtask

  task automatic read_burst(input int k);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vsel = 3'b001 << k; wr = 1'b0; addr = AW'(i); en = 1'b1; cor = 1'b1;
      push(k, '{d: pat(i), ce: 1'b0, ue: 1'b0, a: AW'(i)}, "R2 R3 back-to-back clean read");
    end
    @(negedge clk);
    vsel = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  localparam logic [63:0] D = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs right after reset
    for (int k = 0; k < 3; k++) begin
      n_chk++;
      if (rv[k] !== 1'b0 || ce[k] !== 1'b0 || ue[k] !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 inst%0d: rv=%b ce=%b ue=%b expected 0 0 0", k, rv[k], ce[k], ue[k]);
      end
    end

    // R3 / R2: clean round trip, consecutive reads
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 4; i++) do_write(k, AW'(i), pat(i), '0, '0);
    for (int k = 0; k < 3; k++) read_burst(k);

    // parity scheme
    do_write(0, 8,  D, 64'h1 << 13, '0);
    do_read (0, 8,  1, 1, D ^ (64'h1 << 13), 0, 1, "R4 single data flip");
    do_write(0, 9,  D, '0, 14'h20);
    do_read (0, 9,  1, 1, D, 0, 1, "R4 check bit flip");
    do_write(0, 10, D, 64'h0101_0101_0101_0101, '0);
    do_read (0, 10, 1, 1, D ^ 64'h0101_0101_0101_0101, 0, 1, "R4 eight bytes flipped");
    do_write(0, 11, D, 64'h3 << 16, '0);
    do_read (0, 11, 1, 1, D ^ (64'h3 << 16), 0, 0, "R5 double flip in one byte");
    odd = 1'b0;
    do_write(0, 12, D, '0, '0);
    odd = 1'b1;
    do_read (0, 12, 1, 1, D, 0, 1, "R11 polarity swapped");
    odd = 1'b0;

    // 64-bit SECDED
    do_write(1, 8,  D, 64'h1, '0);
    do_read (1, 8,  1, 1, D, 1, 0, "R6 data bit 0");
    do_write(1, 9,  D, 64'h1 << 63, '0);
    do_read (1, 9,  1, 1, D, 1, 0, "R6 data bit 63");
    do_write(1, 10, D, '0, 14'h8);
    do_read (1, 10, 1, 1, D, 1, 0, "R6 Hamming bit");
    do_write(1, 11, D, '0, 14'h80);
    do_read (1, 11, 1, 1, D, 1, 0, "R6 overall bit");
    do_write(1, 12, D, (64'h1 << 5) | (64'h1 << 40), '0);
    do_read (1, 12, 1, 1, D ^ ((64'h1 << 5) | (64'h1 << 40)), 0, 1, "R7 two data bits");
    do_write(1, 13, D, 64'h1 << 7, 14'h4);
    do_read (1, 13, 1, 1, D ^ (64'h1 << 7), 0, 1, "R7 data plus check bit");
    do_read (1, 8,  0, 1, D ^ 64'h1, 0, 0, "R9 checking disabled");
    do_read (1, 9,  1, 0, D ^ (64'h1 << 63), 1, 0, "R10 detect only");

    // dual 32-bit SECDED
    do_write(2, 8,  D, (64'h1 << 2) | (64'h1 << 50), '0);
    do_read (2, 8,  1, 1, D, 1, 0, "R8 one flip per half");
    do_write(2, 9,  D, '0, 14'h200);
    do_read (2, 9,  1, 1, D, 1, 0, "R8 upper check bit");
    do_write(2, 10, D, 64'h6, '0);
    do_read (2, 10, 1, 1, D ^ 64'h6, 0, 1, "R8 double in lower half");
    do_write(2, 11, D, 64'h6 | (64'h1 << 40), '0);
    do_read (2, 11, 1, 1, D ^ 64'h6, 0, 1, "R12 ue in low half, upper repaired");
    do_write(2, 12, D, (64'h1 << 33) | (64'h1 << 34), '0);
    do_read (2, 12, 1, 1, D ^ ((64'h1 << 33) | (64'h1 << 34)), 0, 1, "R8 double in upper half");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q0.size() + q1.size() + q2.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d reads unanswered expected 0", q0.size() + q1.size() + q2.size());
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2: watchdog expired, run hung");
      finish_run();
    end
  end

endmodule